// File: doc/BRIEF.md
# DS1 Idle Code Generator

This block produces an idle bitstream at the DS1 bit rate that can stand in for user data on any of a set of transmit channels. A two-bit pattern selector picks one of three idle signals: a zero-suppressed pseudo-random sequence of period 2^20-1, a self-framed Extended Superframe (ESF) signal whose payload is all ones, with a framing pattern and a CRC-6 in its framing-bit slots, or unframed all ones (AIS). Every channel that has idle enabled gets the same pattern.

The bitstream advances one bit on each cycle where the DS1 bit enable is high. A 193-bit frame and a 24-frame superframe position is kept at all times. A small state machine holds the active pattern: IDLE_AIS (the reset state), IDLE_QRS and IDLE_ESF. Its only transition is "superframe boundary": when the bit enable is high on the last bit of a superframe, the state moves to the pattern that the selector decodes to. In every other cycle the state holds. For each channel a substitute-data multiplexer picks loopback data, the idle bit or the channel's own user data. Loopback has the highest priority.

Top module: `ds1_idle_gen`

## Requirements
- R1: While reset is asserted and right after it is released, the state is IDLE_AIS, `idle_bit` is 1, and the frame position is bit 0 of frame 1.
- R2: The selector decodes as follows. `pat_sel[0]`=0 selects pseudo-random, whatever `pat_sel[1]` is. `pat_sel`=2'b01 selects ESF. `pat_sel`=2'b11 selects all ones.
- R3: A new selector value takes effect only at the superframe boundary. That is the cycle with `bit_en` high on bit 192 of frame 24. The new pattern starts with bit 0 of frame 1.
- R4: The pseudo-random source is a 20-stage shift register s[19:0]. It is seeded with all ones at reset. On each `bit_en` it shifts left and takes s[19]^s[16] into s[0]. It advances in every mode.
- R5: In pseudo-random mode, `idle_bit` = s[19] OR (s[19:6]==0). As a result the output never has 14 zeros in a row.
- R6: In ESF mode, the framing bit (bit 0) of frames 4, 8, 12, 16, 20 and 24 carries 0,0,1,0,1,1 in that order.
- R7: In ESF mode, the framing bits of frames 2, 6, 10, 14, 18 and 22 carry the CRC-6 of the previous superframe, most significant bit first. The CRC uses x^6+x+1. The register starts at 0 and is fed one bit per `bit_en`, with framing bits taken as 1. The first superframe after reset sends 0 in these slots.
- R8: In ESF mode, the framing bits of the odd frames and all 192 payload bits of every frame are 1.
- R9: In all-ones mode, `idle_bit` is 1 on every bit.
- R10: When `bit_en` is low, the frame position, the shift register, the CRC and the state do not change, so `idle_bit` holds.
- R11: `ch_out[i]` is `loop_data[i]` when `lpbk_sel[i]` is 1. Otherwise it is `idle_bit` when `idle_en[i]` is 1. Otherwise it is `user_data[i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | DS1 bit enable, one pulse per DS1 bit |
| pat_sel | input | 2 | Idle pattern selector (see R2) |
| idle_en | input | NCH | Per-channel idle substitution enable |
| lpbk_sel | input | NCH | Per-channel loopback select, overrides idle |
| user_data | input | NCH | Per-channel user transmit data |
| loop_data | input | NCH | Per-channel loopback data |
| idle_bit | output | 1 | Idle pattern bitstream |
| ch_out | output | NCH | Per-channel substituted transmit data |

## Verification
The idle stream is driven with the selector held steady in each of the three patterns, including the don't-care form 2'b10. Each run lasts long enough that the ESF part crosses several superframe boundaries, which separates the fixed framing pattern from the CRC slots, and the CRC slots of the first superframe from those of later ones. Selector changes at random points inside a superframe show that the switch waits for the boundary, and gaps in `bit_en` show that the stream holds. The channel inputs are random in every cycle, so all combinations of loopback, idle enable and user data are covered, and with them the priority order of the multiplexer.

// File: rtl/ds1_idle_pkg.sv
package ds1_idle_pkg;

    typedef enum logic [1:0] {
        IDLE_AIS = 2'd0,
        IDLE_QRS = 2'd1,
        IDLE_ESF = 2'd2
    } idle_state_e;

    // Selector decode: bit 0 low -> pseudo-random, 01 -> ESF, 11 -> all ones
    function automatic idle_state_e decode_sel(input logic [1:0] sel);
        if (!sel[0])
            return IDLE_QRS;
        else if (!sel[1])
            return IDLE_ESF;
        else
            return IDLE_AIS;
    endfunction

endpackage

// File: rtl/ds1_qrs_gen.sv
module ds1_qrs_gen #(
    parameter int          LEN  = 20,
    parameter int          TAP  = 17,
    parameter int          ZRUN = 14,
    parameter logic [LEN-1:0] SEED = '1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    output logic qrs_bit
);
    localparam int ZW = $clog2(ZRUN + 1);

    logic [LEN-1:0] sr_q;
    logic           fb;

    assign fb      = sr_q[LEN-1] ^ sr_q[TAP-1];
    assign qrs_bit = sr_q[LEN-1] | ~(|sr_q[LEN-1 -: ZRUN]);

    always_ff @(posedge clk) begin
        if (!rst_n)
            sr_q <= SEED;
        else if (adv)
            sr_q <= {sr_q[LEN-2:0], fb};
    end

    // zero-run monitor for the suppression rule
    logic [ZW-1:0] zrun_q;
    always_ff @(posedge clk) begin
        if (!rst_n)
            zrun_q <= '0;
        else if (adv) begin
            if (qrs_bit)
                zrun_q <= '0;
            else if (zrun_q < ZW'(ZRUN))
                zrun_q <= zrun_q + ZW'(1);
        end
    end

    // R5
    zero_run_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zrun_q < ZW'(ZRUN));

    // R4
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sr_q != '0);

endmodule

// File: rtl/ds1_esf_framer.sv
module ds1_esf_framer #(
    parameter int                FRAME_BITS = 193,
    parameter int                SF_FRAMES  = 24,
    parameter int                CRC_W      = 6,
    parameter logic [CRC_W-1:0]  CRC_POLY   = 6'b000011,
    parameter logic [5:0]        FPS        = 6'b001011
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    output logic esf_bit,
    output logic sf_last
);
    localparam int BW    = $clog2(FRAME_BITS);
    localparam int FW    = $clog2(SF_FRAMES);
    localparam int SLOTS = SF_FRAMES / 4;
    localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_BITS - 1);
    localparam logic [FW-1:0] LAST_FRM = FW'(SF_FRAMES - 1);

    logic [BW-1:0]    bit_q;
    logic [FW-1:0]    frm_q;
    logic [CRC_W-1:0] crc_q, crc_hold_q, crc_d;
    logic             crc_din;
    logic             frame_end;
    int               slot;

    assign frame_end = (bit_q == LAST_BIT);
    assign sf_last   = frame_end && (frm_q == LAST_FRM);
    assign slot      = int'(frm_q >> 2);

    // framing bits count as 1 and the idle payload is all ones
    assign crc_din = 1'b1;
    assign crc_d   = {crc_q[CRC_W-2:0], 1'b0} ^
                     ((crc_q[CRC_W-1] ^ crc_din) ? CRC_POLY : '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q      <= '0;
            frm_q      <= '0;
            crc_q      <= '0;
            crc_hold_q <= '0;
        end else if (adv) begin
            if (frame_end) begin
                bit_q <= '0;
                frm_q <= sf_last ? '0 : frm_q + FW'(1);
            end else begin
                bit_q <= bit_q + BW'(1);
            end
            if (sf_last) begin
                crc_hold_q <= crc_d;
                crc_q      <= '0;
            end else begin
                crc_q      <= crc_d;
            end
        end
    end

    always_comb begin
        esf_bit = 1'b1;
        if (bit_q == '0) begin
            if (frm_q[1:0] == 2'd3)
                esf_bit = FPS[SLOTS-1-slot];
            else if (frm_q[1:0] == 2'd1)
                esf_bit = crc_hold_q[CRC_W-1-slot];
        end
    end

    // R3
    pos_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_q <= LAST_BIT) && (frm_q <= LAST_FRM));

    // R10
    pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(bit_q) && $stable(frm_q) && $stable(crc_q));

    // R7
    crc_hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(adv && sf_last) |=> $stable(crc_hold_q));

endmodule

// File: rtl/ds1_chan_mux.sv
module ds1_chan_mux #(
    parameter int NCH = 28
) (
    input  logic           idle_bit,
    input  logic [NCH-1:0] idle_en,
    input  logic [NCH-1:0] lpbk_sel,
    input  logic [NCH-1:0] user_data,
    input  logic [NCH-1:0] loop_data,
    output logic [NCH-1:0] ch_out
);
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        always_comb begin
            if (lpbk_sel[i])
                ch_out[i] = loop_data[i];
            else if (idle_en[i])
                ch_out[i] = idle_bit;
            else
                ch_out[i] = user_data[i];
        end
    end
endmodule

// File: rtl/ds1_idle_gen.sv
module ds1_idle_gen
    import ds1_idle_pkg::*;
#(
    parameter int NCH = 28
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bit_en,
    input  logic [1:0]     pat_sel,
    input  logic [NCH-1:0] idle_en,
    input  logic [NCH-1:0] lpbk_sel,
    input  logic [NCH-1:0] user_data,
    input  logic [NCH-1:0] loop_data,
    output logic           idle_bit,
    output logic [NCH-1:0] ch_out
);
    idle_state_e state_q, state_d;
    logic        qrs_bit, esf_bit, sf_last, boundary;

    assign boundary = bit_en && sf_last;

    ds1_qrs_gen u_qrs (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (bit_en),
        .qrs_bit (qrs_bit)
    );

    ds1_esf_framer u_esf (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (bit_en),
        .esf_bit (esf_bit),
        .sf_last (sf_last)
    );

    // next-state: only the superframe boundary transition exists
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IDLE_AIS: if (boundary) state_d = decode_sel(pat_sel);
            IDLE_QRS: if (boundary) state_d = decode_sel(pat_sel);
            IDLE_ESF: if (boundary) state_d = decode_sel(pat_sel);
            default:  state_d = IDLE_AIS;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= IDLE_AIS;
        else
            state_q <= state_d;
    end

    // outputs
    always_comb begin
        unique case (state_q)
            IDLE_QRS: idle_bit = qrs_bit;
            IDLE_ESF: idle_bit = esf_bit;
            default:  idle_bit = 1'b1;
        endcase
    end

    ds1_chan_mux #(.NCH(NCH)) u_mux (
        .idle_bit  (idle_bit),
        .idle_en   (idle_en),
        .lpbk_sel  (lpbk_sel),
        .user_data (user_data),
        .loop_data (loop_data),
        .ch_out    (ch_out)
    );

    // R3
    state_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary |=> $stable(state_q));

    // R9
    ais_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == IDLE_AIS) |-> idle_bit);

endmodule

// File: tb/ds1_idle_gen_tb.sv
`timescale 1ns/1ps
module ds1_idle_gen_tb;
    localparam int NCH = 28;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           bit_en;
    logic [1:0]     pat_sel;
    logic [NCH-1:0] idle_en, lpbk_sel, user_data, loop_data;
    logic           idle_bit;
    logic [NCH-1:0] ch_out;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    ds1_idle_gen #(.NCH(NCH)) u_dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .pat_sel(pat_sel),
        .idle_en(idle_en), .lpbk_sel(lpbk_sel), .user_data(user_data),
        .loop_data(loop_data), .idle_bit(idle_bit), .ch_out(ch_out)
    );

    // reference model state (0 = AIS, 1 = QRS, 2 = ESF)
    int          m_mode;
    int          m_b, m_f;
    logic [19:0] m_sr;
    logic [5:0]  m_crc, m_hold;
    logic        m_last_en;

    function automatic int dec(input logic [1:0] s);
        if (!s[0]) return 1;
        if (!s[1]) return 2;
        return 0;
    endfunction

    function automatic logic exp_idle();
        logic [5:0] fps = 6'b001011;
        if (m_mode == 0) return 1'b1;
        if (m_mode == 1) return m_sr[19] | (m_sr[19:6] == 14'd0);
        if (m_b != 0) return 1'b1;
        if (m_f % 4 == 3) return fps[5 - m_f/4];
        if (m_f % 4 == 1) return m_hold[5 - m_f/4];
        return 1'b1;
    endfunction

    function automatic string tag();
        string t;
        if (m_mode == 0)                   t = "R2 R9";
        else if (m_mode == 1)              t = "R2 R4 R5";
        else if (m_b == 0 && m_f % 4 == 3) t = "R2 R6";
        else if (m_b == 0 && m_f % 4 == 1) t = "R2 R7";
        else                               t = "R2 R8";
        if (dec(pat_sel) != m_mode) t = {t, " R3"};
        if (!m_last_en)             t = {t, " R10"};
        return t;
    endfunction

    function automatic logic [NCH-1:0] exp_ch(input logic ib);
        logic [NCH-1:0] r;
        for (int i = 0; i < NCH; i++)
            r[i] = lpbk_sel[i] ? loop_data[i] : (idle_en[i] ? ib : user_data[i]);
        return r;
    endfunction

    task automatic model_reset();
        m_mode = 0; m_b = 0; m_f = 0;
        m_sr = '1; m_crc = '0; m_hold = '0; m_last_en = 1'b1;
    endtask

    task automatic model_adv();
        logic [5:0] nxt;
        nxt = {m_crc[4:0], 1'b0} ^ ((m_crc[5] ^ 1'b1) ? 6'b000011 : 6'b0);
        if (m_b == 192 && m_f == 23) begin
            m_hold = nxt; m_crc = '0; m_mode = dec(pat_sel);
        end else begin
            m_crc = nxt;
        end
        if (m_b == 192) begin m_b = 0; m_f = (m_f + 1) % 24; end
        else m_b++;
        m_sr = {m_sr[18:0], m_sr[19] ^ m_sr[16]};
    endtask

    task automatic check_now();
        logic e;
        e = exp_idle();
        n_checks++;
        if (idle_bit !== e) begin
            n_fail++;
            $display("FAIL %s idle_bit frame %0d bit %0d: got %b exp %b",
                     tag(), m_f + 1, m_b, idle_bit, e);
        end
        n_checks++;
        if (ch_out !== exp_ch(e)) begin
            n_fail++;
            $display("FAIL R11 ch_out: got %h exp %h", ch_out, exp_ch(e));
        end
    endtask

    task automatic rand_chan();
        idle_en   = NCH'({$urandom, $urandom});
        lpbk_sel  = NCH'({$urandom, $urandom});
        user_data = NCH'({$urandom, $urandom});
        loop_data = NCH'({$urandom, $urandom});
    endtask

    // one bit period of stimulus, check, then model update
    task automatic step(input int en_pct);
        @(negedge clk);
        bit_en = (($urandom % 100) < en_pct);
        rand_chan();
        #1;
        check_now();
        if (bit_en) model_adv();
        m_last_en = bit_en;
    endtask

    task automatic run(input logic [1:0] sel, input int n, input int en_pct);
        pat_sel = sel;
        for (int k = 0; k < n; k++) step(en_pct);
    endtask

    initial begin
        #1_900_000;
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1D1E));
        rst_n = 1'b0; bit_en = 1'b1; pat_sel = 2'b00;
        rand_chan();
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        n_checks++;
        if (idle_bit !== 1'b1) begin
            n_fail++;
            $display("FAIL R1 idle_bit in reset: got %b exp 1", idle_bit);
        end
        rst_n = 1'b1;
        bit_en = 1'b0;
        #1;
        // R1: first cycle out of reset, frame 1 bit 0, AIS
        check_now();

        // selector changed right after reset: AIS holds for a superframe (R3)
        run(2'b00, 8000, 75);
        run(2'b01, 22000, 75);
        run(2'b11, 6000, 75);
        run(2'b10, 7000, 75);
        // R10: long hold with enable low
        run(2'b01, 40, 0);
        run(2'b01, 6000, 100);
        // random selector changes inside superframes (R3)
        for (int p = 0; p < 20; p++)
            run(2'($urandom), 300 + ($urandom % 700), 80);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule